// File: doc/BRIEF.md
# Two-Region Flash Erase Range Walker

This block takes an erase request made of a byte start address and a byte length. It checks the request against a fixed flash layout with two regions. The lower region is made of small boot blocks and the upper region is made of large main blocks. If the request is valid, the block walks through it one block at a time and sends one block-erase command per block to a downstream erase engine. That engine has a plain start/done/fail handshake.

The block size in use changes when the walk crosses from the small-block region into the large-block region. The start of a request is checked against the block size of the region that holds the start. The end of a request is checked against the block size of the region found for the end. When the request finishes, a one-cycle response gives a status code. While the walk runs, the address of the block being erased is visible on the command port, and a count of the blocks already completed is also visible.

Default layout:
- Region 0 begins at 0x0 and holds 8 blocks of 0x4000 bytes.
- Region 1 begins at 0x20000 and holds 31 blocks of 0x20000 bytes.
- The device therefore ends at 0x400000.

Top module: `erase_range_walker`

## Requirements
- R1: After reset the block is in the following state:
  - `busy` is 0.
  - `er_start` is 0.
  - `rsp_valid` is 0.
  - `blk_count` is 0.
- R2: A request whose end (`req_addr` + `req_len`, computed without wrap-around) lies above 0x400000 is rejected with `rsp_code` 2'b01 and no erase command. An end of exactly 0x400000 is accepted.
- R3: The start address must be a multiple of the block size of the region that contains it. That size is 0x4000 below 0x20000 and 0x20000 at or above 0x20000. A start that breaks this rule is rejected with code 2'b01.
- R4: The end address must be a multiple of the block size of the region found for it. An end at or above 0x20000 counts as region 1, so an end of exactly 0x20000 belongs to region 1. An end that breaks this rule is rejected with code 2'b01.
- R5: Erase commands go out in ascending address order, one `er_start` pulse per block, starting at `req_addr`. Each command's address is the previous one plus the block size of the region that holds the previous address. A new pulse is issued only after `er_done` has answered the previous one.
- R6: Once the walk reaches 0x20000, the step size changes from 0x4000 to 0x20000.
- R7: If an erase reports `er_fail` together with `er_done`, the walk stops and answers with code 2'b10. In that case `blk_count` holds the number of blocks that completed before the failing one.
- R8: A walk with no failure answers with code 2'b00, and `blk_count` equals the number of blocks erased.
- R9: A valid request with zero length answers with code 2'b00 and issues no erase command.
- R10: While `busy` is 1, `req_valid` is ignored.
- R11: `rsp_valid` is a single-cycle pulse. Its timing is:
  - For a rejected request or a zero-length request, it comes in the cycle after the request is accepted.
  - Otherwise, it comes in the cycle after the `er_done` of the last block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | AW | Byte start address |
| req_len | input | AW | Byte length |
| busy | output | 1 | A walk is in progress |
| er_start | output | 1 | One-cycle command to erase the block at `er_addr` |
| er_addr | output | AW | Address of the block being erased |
| er_done | input | 1 | Downstream erase finished |
| er_fail | input | 1 | Qualifies `er_done`: the erase failed |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | 00 done, 01 invalid request, 10 erase failed |
| blk_count | output | CW | Blocks completed in the current or last request |

## Verification
Rejected requests and zero-length requests must answer in the very next cycle. The bench samples `rsp_valid` at the first falling edge after the accepting rising edge and counts any delay as an error.

For walked requests, `er_start` is valid from the accepting edge onward. The bench's downstream model answers `er_done` three edges after it sees `er_start`. The response must then follow the last `er_done` by exactly one cycle, so the bench remembers whether `er_done` was high at the previous falling edge when `rsp_valid` appears.

The bench logs every erase address at the rising edge where `er_start` is sampled. It checks the address sequence after the response arrives.

// File: rtl/erase_range_walker.sv
module erase_range_walker #(
  parameter int AW     = 32,
  parameter int R0_BLK = 32'h4000,
  parameter int R0_N   = 8,
  parameter int R1_BLK = 32'h20000,
  parameter int R1_N   = 31,
  parameter int CW     = $clog2(R0_N + R1_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_len,
  output logic          busy,
  output logic          er_start,
  output logic [AW-1:0] er_addr,
  input  logic          er_done,
  input  logic          er_fail,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic [CW-1:0] blk_count
);

  localparam logic [AW:0] R1_OFF  = (AW+1)'(R0_BLK) * (AW+1)'(R0_N);
  localparam logic [AW:0] DEV_END = R1_OFF + (AW+1)'(R1_BLK) * (AW+1)'(R1_N);
  localparam logic [AW:0] M0      = (AW+1)'(R0_BLK - 1);
  localparam logic [AW:0] M1      = (AW+1)'(R1_BLK - 1);

  localparam logic [1:0] C_DONE = 2'b00;
  localparam logic [1:0] C_BAD  = 2'b01;
  localparam logic [1:0] C_FAIL = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;
  state_t state;

  logic [AW-1:0] cur_addr, rem;
  logic          in_main;

  wire [AW:0] req_start  = {1'b0, req_addr};
  wire [AW:0] req_end    = req_start + {1'b0, req_len};
  wire        start_main = req_start >= R1_OFF;
  wire        end_main   = req_end >= R1_OFF;
  wire        range_bad  = req_end > DEV_END;
  wire        start_bad  = (req_start & (start_main ? M1 : M0)) != '0;
  wire        end_bad    = (req_end & (end_main ? M1 : M0)) != '0;
  wire        req_bad    = range_bad | start_bad | end_bad;

  wire [AW-1:0] step      = in_main ? AW'(R1_BLK) : AW'(R0_BLK);
  wire [AW-1:0] next_addr = cur_addr + step;
  wire          last_blk  = rem == step;

  assign busy     = state != S_IDLE;
  assign er_start = state == S_ISSUE;
  assign er_addr  = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      rem       <= '0;
      in_main   <= 1'b0;
      blk_count <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= C_DONE;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          blk_count <= '0;
          cur_addr  <= req_addr;
          rem       <= req_len;
          in_main   <= start_main;
          if (req_bad) begin
            rsp_valid <= 1'b1;
            rsp_code  <= C_BAD;
          end else if (req_len == '0) begin
            rsp_valid <= 1'b1;
            rsp_code  <= C_DONE;
          end else begin
            state <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (er_done) begin
          if (er_fail) begin
            state     <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_code  <= C_FAIL;
          end else begin
            blk_count <= blk_count + 1'b1;
            cur_addr  <= next_addr;
            rem       <= rem - step;
            if (!in_main && {1'b0, next_addr} == R1_OFF) in_main <= 1'b1;
            if (last_blk) begin
              state     <= S_IDLE;
              rsp_valid <= 1'b1;
              rsp_code  <= C_DONE;
            end else begin
              state <= S_ISSUE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_start |=> !er_start);

  // R5
  start_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_start |-> (({1'b0, er_addr} & M0) == '0) &&
                 ({1'b0, er_addr} < R1_OFF || (({1'b0, er_addr} & M1) == '0)));

  // R2
  start_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_start |-> {1'b0, er_addr} < DEV_END);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  bad_no_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == C_BAD) |-> blk_count == '0);

  // R10
  busy_hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(er_done)) |-> $stable(er_addr));

  // R11
  no_issue_on_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !er_start);

endmodule

// File: tb/erase_range_walker_bench.sv
`timescale 1ns/1ps
module erase_range_walker_bench;
  localparam int AW = 32;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0, req_len = '0;
  logic busy, er_start, rsp_valid;
  logic [AW-1:0] er_addr;
  logic er_done = 1'b0, er_fail = 1'b0;
  logic [1:0] rsp_code;
  logic [CW-1:0] blk_count;

  always #2.5 clk = ~clk;

  erase_range_walker u_erase_range_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .er_start(er_start), .er_addr(er_addr),
    .er_done(er_done), .er_fail(er_fail), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .blk_count(blk_count));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  int total = 0, base = 0, dly = 0, fail_rel = -1;
  logic [AW-1:0] log_a [64];

  always @(posedge clk) begin
    er_done <= 1'b0;
    er_fail <= 1'b0;
    if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        er_done <= 1'b1;
        er_fail <= ((total - 1 - base) == fail_rel);
      end
    end
    if (er_start) begin
      log_a[(total - base) % 64] <= er_addr;
      total <= total + 1;
      dly <= 3;
    end
  end

  // addr, len, code, n_erase, last_addr
  localparam int NV = 14;
  localparam logic [105:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_4000, 2'd0, 8'd1,  32'h0000_0000},
    {32'h0000_8000, 32'h0000_C000, 2'd0, 8'd3,  32'h0001_0000},
    {32'h0001_8000, 32'h0002_8000, 2'd0, 8'd3,  32'h0002_0000},
    {32'h0000_0000, 32'h0040_0000, 2'd0, 8'd39, 32'h003E_0000},
    {32'h0002_0000, 32'h0004_0000, 2'd0, 8'd2,  32'h0004_0000},
    {32'h003E_0000, 32'h0002_0000, 2'd0, 8'd1,  32'h003E_0000},
    {32'h0001_0000, 32'h0001_0000, 2'd0, 8'd4,  32'h0001_C000},
    {32'h003E_0000, 32'h0004_0000, 2'd1, 8'd0,  32'h0000_0000},
    {32'hFFFF_C000, 32'h0000_8000, 2'd1, 8'd0,  32'h0000_0000},
    {32'h0000_2000, 32'h0000_4000, 2'd1, 8'd0,  32'h0000_0000},
    {32'h0002_4000, 32'h0002_0000, 2'd1, 8'd0,  32'h0000_0000},
    {32'h0001_C000, 32'h0000_8000, 2'd1, 8'd0,  32'h0000_0000},
    {32'h0000_4000, 32'h0000_2000, 2'd1, 8'd0,  32'h0000_0000},
    {32'h0000_4000, 32'h0000_0000, 2'd0, 8'd0,  32'h0000_0000}
  };

  logic [1:0] got_code;
  logic [CW-1:0] got_cnt;
  int got_n, got_wait;
  bit got_after_done, got_rsp;

  task automatic run(input logic [AW-1:0] a, input logic [AW-1:0] l,
                     input int frel, input bit poke);
    int cyc;
    bit prev_done;
    base = total;
    fail_rel = frel;
    @(negedge clk);
    req_addr = a; req_len = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_rsp = 0; got_wait = 0; prev_done = 0; got_after_done = 0;
    for (cyc = 0; cyc < 2000; cyc++) begin
      if (rsp_valid) begin
        got_rsp = 1; got_code = rsp_code; got_cnt = blk_count;
        got_wait = cyc; got_after_done = prev_done;
        break;
      end
      prev_done = er_done;
      if (poke && cyc == 4) begin req_addr = 32'h2000; req_valid = 1'b1; end
      @(negedge clk);
      req_valid = 1'b0;
    end
    @(negedge clk);
    got_n = total - base;
    fail_rel = -1;
  endtask

  task automatic check_seq(input logic [AW-1:0] start);
    bit ok = 1;
    logic [AW-1:0] exp = start;
    int bad_i = -1;
    for (int i = 0; i < got_n && i < 64; i++) begin
      if (log_a[i] !== exp && ok) begin ok = 0; bad_i = i; end
      exp = exp + ((exp < 32'h20000) ? 32'h4000 : 32'h20000);
    end
    chk(ok, "R5/R6 erase address sequence", bad_i >= 0 ? log_a[bad_i] : 0, bad_i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 0 && er_start == 0 && rsp_valid == 0 && blk_count == 0,
        "R1 reset state", {busy, er_start, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [105:0] e;
      e = VEC[v];
      run(e[105:74], e[73:42], -1, 0);
      chk(got_rsp && got_code == e[41:40], "R2/R3/R4/R8/R9 response code", got_code, e[41:40]);
      chk(got_n == int'(e[39:32]), "R8/R9 erase count", got_n, e[39:32]);
      chk(got_cnt == e[37:32], "R8 blk_count", got_cnt, e[37:32]);
      if (got_n > 0) begin
        chk(log_a[0] == e[105:74], "R5 first erase address", log_a[0], e[105:74]);
        chk(log_a[(got_n-1) % 64] == e[31:0], "R6 last erase address", log_a[(got_n-1) % 64], e[31:0]);
        check_seq(e[105:74]);
        // R11
        chk(got_after_done, "R11 response one cycle after last done", got_wait, 1);
      end else begin
        // R11
        chk(got_wait == 0, "R11 immediate response", got_wait, 0);
      end
    end

    // R7: failure on third block
    run(32'h0, 32'h10000, 2, 0);
    chk(got_code == 2'b10, "R7 fail code", got_code, 2);
    chk(got_n == 3, "R7 stops after failing block", got_n, 3);
    chk(got_cnt == 2, "R7 blk_count before failure", got_cnt, 2);

    // R7: failure on first block in region 1
    run(32'h20000, 32'h60000, 0, 0);
    chk(got_code == 2'b10 && got_n == 1 && got_cnt == 0, "R7 first-block fail", got_cnt, 0);

    // R10: request strobe while busy is ignored
    run(32'h0, 32'h8000, -1, 1);
    chk(got_code == 2'b00 && got_n == 2, "R10 busy request ignored", got_n, 2);
    repeat (4) @(negedge clk);
    chk(!rsp_valid && !busy, "R10 no late response", {rsp_valid, busy}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule